// File: doc/BRIEF.md
# Slave Address Match and Wake-Up Filter

This block sits beside a serial receiver that is wired as a bus slave. Each time the receiver finishes a byte it raises a one-cycle valid strobe, together with a flag that marks whether the byte belongs to the address phase of a transfer. For an address byte, the block compares it with a host-programmed station address. A hit raises a coincidence flag. A miss drops a ready/release flag, so the host can see that the transfer is meant for another station.

An optional mask leaves the lowest address bit out of the comparison. In that case the upper seven bits decide the match on their own, and the lowest bit is free to carry a direction or similar qualifier. In wake-up mode the block withholds the byte-done interrupt unless an address byte hit. A host that sleeps through bus traffic is therefore woken only when it is the addressed station. With wake-up mode off, every completed byte raises the interrupt.

Byte assembly, clocking of the serial line and protocol sequencing belong to other blocks.

Top module: `addr_match_wake`

## Requirements
- R1: After reset the station address register holds 0x00, and the coincidence flag, the release flag and the interrupt are all 0.
- R2: A host write (`host_wr` high for one cycle) loads `host_addr` into the station address register. Address bytes strobed in later cycles are compared with the new value.
- R3: With the mask off, an address byte equal to the station address in all 8 bits sets `coin_flag` to 1 in the cycle after the strobe.
- R4: With `lsb_mask` high, bit 0 of both values is ignored and only bits 7 down to 1 are compared. For example, 0x55 matches a station address of 0x54, but 0xD4 does not.
- R5: An address byte that does not match clears `rel_flag` to 0 and `coin_flag` to 0 in the cycle after the strobe.
- R6: `rel_set` sets `rel_flag` to 1. If a mismatching address byte is strobed in the same cycle, the clear wins.
- R7: With `wake_mode` high, `irq` is raised only for an address byte that matches. It stays low for data bytes and for address bytes that miss.
- R8: With `wake_mode` low, `irq` is raised for every strobed byte, whether it is an address or data byte and whether it matches or not.
- R9: `irq` is high for exactly the one cycle after each qualifying strobe.
- R10: The flags change only on a strobe with `addr_phase` high. A data byte (strobe with `addr_phase` low) leaves both flags unchanged.
- R11: `coin_clr` or `xfer_start` clears `coin_flag`. An address byte strobed in the same cycle takes precedence and sets the flag to its comparison result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the station address |
| host_addr | input | 8 | Station address value to load |
| lsb_mask | input | 1 | Ignore bit 0 in the comparison |
| wake_mode | input | 1 | Gate the interrupt on an address hit |
| rel_set | input | 1 | Host sets the release flag |
| coin_clr | input | 1 | Host clears the coincidence flag |
| xfer_start | input | 1 | New transfer starting; clears the coincidence flag |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is complete |
| addr_phase | input | 1 | The strobed byte is an address byte |
| coin_flag | output | 1 | Address coincidence flag |
| rel_flag | output | 1 | Release/ready flag |
| irq | output | 1 | Byte-done interrupt pulse |

## Verification
The assertions check on every cycle that an address hit is followed by a set coincidence flag and that a miss is followed by a cleared release flag. They also check that wake-up mode never lets a miss raise the interrupt, that the flags hold still when nothing acts on them, and that every interrupt pulse follows a byte strobe. The bench scenarios are needed for the value-dependent parts. These are the masked-bit corner values, comparison against a freshly written address, the precedence between a strobe and the host's set and clear controls in the same cycle, and the full interrupt pattern across mixed address and data traffic in both modes.

// File: rtl/amw_pkg.sv
package amw_pkg;
  localparam int unsigned AMW_ADDR_W   = 8;
  localparam int unsigned AMW_MASK_LSB = 1;
  localparam logic [AMW_ADDR_W-1:0] AMW_ADDR_RST = '0;
endpackage

// File: rtl/amw_addr_reg.sv
module amw_addr_reg #(
  parameter int unsigned W = amw_pkg::AMW_ADDR_W,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] station
);
  always_ff @(posedge clk) begin
    if (!rst_n)     station <= RST_VAL;
    else if (wr_en) station <= wr_data;
  end

  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> station == $past(wr_data));
endmodule

// File: rtl/amw_compare.sv
module amw_compare #(
  parameter int unsigned W     = amw_pkg::AMW_ADDR_W,
  parameter int unsigned NMASK = amw_pkg::AMW_MASK_LSB
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] station,
  input  logic         lsb_mask,
  output logic         hit
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < NMASK) begin : g_maskable
      assign bit_ok[i] = lsb_mask | (rx_byte[i] == station[i]);
    end else begin : g_fixed
      assign bit_ok[i] = (rx_byte[i] == station[i]);
    end
  end

  assign hit = &bit_ok;

  always_comb begin
    if (!lsb_mask) a_r3_full_eq: assert (hit == (rx_byte == station));
  end
endmodule

// File: rtl/amw_flags.sv
module amw_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_strobe,
  input  logic hit,
  input  logic rel_set,
  input  logic coin_clr,
  input  logic xfer_start,
  output logic coin_flag,
  output logic rel_flag
);
  logic coin_kill;
  assign coin_kill = coin_clr | xfer_start;

  always_ff @(posedge clk) begin
    if (!rst_n)           coin_flag <= 1'b0;
    else if (addr_strobe) coin_flag <= hit;
    else if (coin_kill)   coin_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    rel_flag <= 1'b0;
    else if (addr_strobe && !hit)  rel_flag <= 1'b0;
    else if (rel_set)              rel_flag <= 1'b1;
  end

  a_r3_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && hit) |=> coin_flag);
  a_r5_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && !hit) |=> (!rel_flag && !coin_flag));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_strobe && !coin_kill && !rel_set) |=> ($stable(coin_flag) && $stable(rel_flag)));
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_strobe && coin_kill) |=> !coin_flag);
endmodule

// File: rtl/amw_irq_gen.sv
module amw_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic addr_phase,
  input  logic hit,
  input  logic wake_mode,
  output logic irq
);
  logic fire;
  assign fire = rx_valid & (~wake_mode | (addr_phase & hit));

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire;
  end

  a_r7_wake_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && wake_mode && !(addr_phase && hit)) |=> !irq);
  a_r9_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_valid));
endmodule

// File: rtl/addr_match_wake.sv
module addr_match_wake (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [7:0] host_addr,
  input  logic       lsb_mask,
  input  logic       wake_mode,
  input  logic       rel_set,
  input  logic       coin_clr,
  input  logic       xfer_start,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  input  logic       addr_phase,
  output logic       coin_flag,
  output logic       rel_flag,
  output logic       irq
);
  import amw_pkg::*;

  logic [AMW_ADDR_W-1:0] station;
  logic                  hit;
  logic                  addr_strobe;

  assign addr_strobe = rx_valid & addr_phase;

  amw_addr_reg #(.W(AMW_ADDR_W), .RST_VAL(AMW_ADDR_RST)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wr_data(host_addr), .station(station));

  amw_compare #(.W(AMW_ADDR_W), .NMASK(AMW_MASK_LSB)) u_cmp (
    .rx_byte(rx_byte), .station(station), .lsb_mask(lsb_mask), .hit(hit));

  amw_flags u_flags (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .hit(hit),
    .rel_set(rel_set), .coin_clr(coin_clr), .xfer_start(xfer_start),
    .coin_flag(coin_flag), .rel_flag(rel_flag));

  amw_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .addr_phase(addr_phase),
    .hit(hit), .wake_mode(wake_mode), .irq(irq));

  a_r8_every_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !wake_mode) |=> irq);
endmodule

// File: tb/test_addr_match_wake.sv
module test_addr_match_wake;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, lsb_mask = 0, wake_mode = 0, rel_set = 0, coin_clr = 0, xfer_start = 0;
  logic [7:0] host_addr = 0, rx_byte = 0;
  logic rx_valid = 0, addr_phase = 0;
  logic coin_flag, rel_flag, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_match_wake i_addr_match_wake (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .lsb_mask(lsb_mask), .wake_mode(wake_mode), .rel_set(rel_set),
    .coin_clr(coin_clr), .xfer_start(xfer_start), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .addr_phase(addr_phase),
    .coin_flag(coin_flag), .rel_flag(rel_flag), .irq(irq));

  function automatic bit want_hit(input logic [7:0] b, input logic [7:0] st, input bit m);
    return m ? (b[7:1] == st[7:1]) : (b == st);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_addr(input logic [7:0] a);
    @(negedge clk); host_wr = 1; host_addr = a;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic pulse_rel;
    @(negedge clk); rel_set = 1;
    @(negedge clk); rel_set = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit ap);
    @(negedge clk); rx_byte = b; rx_valid = 1; addr_phase = ap;
    @(negedge clk); rx_valid = 0; addr_phase = 0;
  endtask

  task automatic t_reset;
    chk("R1 coin", coin_flag, 1'b0);
    chk("R1 rel", rel_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    send(8'h00, 1);
    chk("R1 reg zero", coin_flag, 1'b1);
  endtask

  task automatic t_full_match;
    lsb_mask = 0; wake_mode = 0;
    write_addr(8'hA6);
    send(8'hA6, 1);
    chk("R2/R3 coin", coin_flag, want_hit(8'hA6, 8'hA6, 0));
    send(8'hA7, 1);
    chk("R3 lsb matters", coin_flag, want_hit(8'hA7, 8'hA6, 0));
  endtask

  task automatic t_mask;
    lsb_mask = 1;
    write_addr(8'h54);
    send(8'h55, 1);
    chk("R4 0x55", coin_flag, want_hit(8'h55, 8'h54, 1));
    send(8'hD4, 1);
    chk("R4 0xD4", coin_flag, want_hit(8'hD4, 8'h54, 1));
    lsb_mask = 0;
  endtask

  task automatic t_release;
    write_addr(8'h3C);
    pulse_rel;
    chk("R6 set", rel_flag, 1'b1);
    send(8'h3C, 1);
    chk("R6 hit keeps", rel_flag, 1'b1);
    send(8'h3D, 1);
    chk("R5 rel", rel_flag, 1'b0);
    chk("R5 coin", coin_flag, 1'b0);
    @(negedge clk); rel_set = 1; rx_byte = 8'h11; rx_valid = 1; addr_phase = 1;
    @(negedge clk); rel_set = 0; rx_valid = 0; addr_phase = 0;
    chk("R6 clear wins", rel_flag, 1'b0);
  endtask

  task automatic t_data_hold;
    send(8'h3C, 1);
    pulse_rel;
    send(8'h00, 0);
    chk("R10 coin held", coin_flag, 1'b1);
    chk("R10 rel held", rel_flag, 1'b1);
  endtask

  task automatic t_clear;
    @(negedge clk); coin_clr = 1;
    @(negedge clk); coin_clr = 0;
    chk("R11 host clr", coin_flag, 1'b0);
    send(8'h3C, 1);
    @(negedge clk); xfer_start = 1;
    @(negedge clk); xfer_start = 0;
    chk("R11 xfer clr", coin_flag, 1'b0);
    @(negedge clk); xfer_start = 1; rx_byte = 8'h3C; rx_valid = 1; addr_phase = 1;
    @(negedge clk); xfer_start = 0; rx_valid = 0; addr_phase = 0;
    chk("R11 strobe wins", coin_flag, 1'b1);
  endtask

  task automatic t_irq_plain;
    wake_mode = 0;
    send(8'h99, 1);
    chk("R8 miss addr", irq, 1'b1);
    @(negedge clk);
    chk("R9 one cycle", irq, 1'b0);
    send(8'h12, 0);
    chk("R8 data", irq, 1'b1);
  endtask

  task automatic t_irq_wake;
    wake_mode = 1;
    send(8'h99, 1);
    chk("R7 miss", irq, 1'b0);
    send(8'h3C, 0);
    chk("R7 data", irq, 1'b0);
    send(8'h3C, 1);
    chk("R7 hit", irq, 1'b1);
    @(negedge clk);
    chk("R9 drop", irq, 1'b0);
    wake_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_full_match;
    t_mask;
    t_release;
    t_data_hold;
    t_clear;
    t_irq_plain;
    t_irq_wake;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule